// File: doc/BRIEF.md
# Burst-Paced Command Transmit Sequencer

This block pushes one command, held as a byte stream in a local buffer, into the single-byte data FIFO register of a security coprocessor. It masters a byte-wide register bus and uses only two device registers: the status register and the data register. It paces the transfer by the burst count the device advertises and ends by starting the command with the go bit. Locality has already been acquired when the block is started, and the response is read by other logic.

A run begins with a one-cycle `start` and a nonzero `cmd_len`. The block first checks that the device is ready to take a command, and aborts any pending work if it is not. It then writes every byte but the last in chunks, each chunk no longer than a freshly fetched burst count. The final byte is sent on its own. The block confirms that the device no longer expects data, then writes go. It ends with a one-cycle `done`. On failure, `err` is raised with `done` and `err_code` holds the cause.

Top module: `cmd_tx_seq`

## Requirements
- R1: After reset `busy`, `done`, `err` and `reg_req` are low, and no bus request is made while the block is idle.
- R2: A run starts with a byte read of the status register (offset 0x18). If bit 6 (command-ready) is set, no write to the status register comes before data is sent.
- R3: If command-ready is clear at the start, the block writes 0x40 to the status register and then polls the status register until bit 6 is set.
- R4: The burst count is read as the low byte at offset 0x19 followed by the high byte at 0x1A and assembled as high*256+low. A zero count causes another fetch. Byte 0x18 is never read as part of a fetch.
- R5: If the count is still zero `BURST_TMO` cycles after the fetch began, the run ends with `err` set and `err_code` = 0x00.
- R6: All bytes except the last go to the data register (offset 0x24) in buffer order. A chunk holds at most the fetched count. After each chunk the block polls until status bits 7 (valid) and 3 (data-expect) are both set, then fetches a new count.
- R7: The last byte is written on its own, after which the block polls for valid. If data-expect is still set, the run fails with `err_code` equal to that status byte, and go is not written.
- R8: A successful run writes 0x20 to the status register once and then pulses `done` with `err` low.
- R9: A status poll that is not satisfied within `WAIT_TMO` cycles ends the run with `err`, and `err_code` is the last status byte read.
- R10: With a length of 1, no burst count is fetched; the only byte is sent as the last byte.
- R11: A `start` with `cmd_len` = 0 is ignored: the block issues no bus access and stays idle.
- R12: Once `reg_req` is raised it stays high, with address, direction and write data unchanged, until `reg_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored when busy) |
| cmd_len | input | LEN_W | Number of command bytes |
| buf_addr | output | LEN_W | Index into the command buffer |
| buf_data | input | 8 | Buffer byte at `buf_addr`, same cycle |
| reg_req | output | 1 | Bus access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 8 | Register byte offset |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid with `reg_ack` |
| reg_ack | input | 1 | Access complete |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Run failed (valid with `done`) |
| err_code | output | 8 | Failure cause: status byte, or 0x00 for burst timeout |

## Verification
The main transfer is tried with a burst count much smaller than the command, which forces several chunks and fetches. It is also tried with a count of 256, whose low byte is zero, which shows whether the two count bytes are combined in the right order. A device that starts not ready and returns zero counts a few times covers the abort path and the fetch retry. Error runs then separate the three failure causes by their codes: a device that keeps expecting data, a count that stays zero, and a device that never becomes ready. The single-byte and zero-length commands complete the set.

// File: rtl/cmd_tx_seq.sv
module cmd_tx_seq #(
  parameter int LEN_W = 11,
  parameter logic [7:0] STS_ADDR = 8'h18,
  parameter logic [7:0] DATA_ADDR = 8'h24,
  parameter longint unsigned BURST_TMO = 64'd500_000_000,
  parameter longint unsigned WAIT_TMO = 64'd30_000_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] cmd_len,
  output logic [LEN_W-1:0] buf_addr,
  input  logic [7:0]       buf_data,
  output logic             reg_req,
  output logic             reg_we,
  output logic [7:0]       reg_addr,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata,
  input  logic             reg_ack,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [7:0]       err_code
);
  localparam longint unsigned TMO_MAX = (WAIT_TMO > BURST_TMO) ? WAIT_TMO : BURST_TMO;
  localparam int TMO_W = $clog2(TMO_MAX + 1);
  localparam logic [TMO_W-1:0] BURST_LIM = TMO_W'(BURST_TMO);
  localparam logic [TMO_W-1:0] WAIT_LIM = TMO_W'(WAIT_TMO);

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_ABORT, S_WAIT, S_BLO, S_BHI, S_CHUNK, S_LAST, S_GO
  } state_t;
  typedef enum logic [1:0] {K_RDY, K_EXP, K_VAL} kind_t;

  state_t           state;
  kind_t            kind;
  logic [LEN_W-1:0] len_q, idx;
  logic [15:0]      left;
  logic [7:0]       blo, code_q, mask;
  logic [TMO_W-1:0] tmo;
  logic             done_q, err_q;

  always_comb begin
    case (kind)
      K_RDY:   mask = 8'h40;
      K_EXP:   mask = 8'h88;
      default: mask = 8'h80;
    endcase
  end

  wire              met     = (reg_rdata & mask) == mask;
  wire [15:0]       bcnt    = {reg_rdata, blo};
  wire [LEN_W-1:0]  last_ix = len_q - LEN_W'(1);
  wire [LEN_W-1:0]  nxt_ix  = idx + LEN_W'(1);

  assign busy      = state != S_IDLE;
  assign reg_req   = busy;
  assign reg_we    = state inside {S_ABORT, S_CHUNK, S_LAST, S_GO};
  assign reg_addr  = (state inside {S_CHUNK, S_LAST}) ? DATA_ADDR :
                     (state == S_BLO) ? STS_ADDR + 8'd1 :
                     (state == S_BHI) ? STS_ADDR + 8'd2 : STS_ADDR;
  assign reg_wdata = (state == S_ABORT) ? 8'h40 :
                     (state == S_GO) ? 8'h20 :
                     (state inside {S_CHUNK, S_LAST}) ? buf_data : 8'h00;
  assign buf_addr  = (state == S_LAST) ? last_ix : idx;
  assign done      = done_q;
  assign err       = err_q;
  assign err_code  = code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      kind   <= K_RDY;
      len_q  <= '0;
      idx    <= '0;
      left   <= '0;
      blo    <= '0;
      code_q <= '0;
      tmo    <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (tmo != '1) tmo <= tmo + 1'b1;
      case (state)
        S_IDLE:
          if (start && cmd_len != '0) begin
            len_q  <= cmd_len;
            idx    <= '0;
            code_q <= '0;
            state  <= S_CHK;
          end
        S_CHK:
          if (reg_ack) begin
            if (reg_rdata[6]) begin
              tmo   <= '0;
              state <= (len_q == LEN_W'(1)) ? S_LAST : S_BLO;
            end else begin
              state <= S_ABORT;
            end
          end
        S_ABORT:
          if (reg_ack) begin
            tmo   <= '0;
            kind  <= K_RDY;
            state <= S_WAIT;
          end
        S_WAIT:
          if (reg_ack) begin
            if (met) begin
              tmo <= '0;
              case (kind)
                K_RDY: state <= (len_q == LEN_W'(1)) ? S_LAST : S_BLO;
                K_EXP: state <= (idx == last_ix) ? S_LAST : S_BLO;
                default:
                  if (reg_rdata[3]) begin
                    state  <= S_IDLE;
                    done_q <= 1'b1;
                    err_q  <= 1'b1;
                    code_q <= reg_rdata;
                  end else begin
                    state <= S_GO;
                  end
              endcase
            end else if (tmo >= WAIT_LIM) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
              err_q  <= 1'b1;
              code_q <= reg_rdata;
            end
          end
        S_BLO:
          if (reg_ack) begin
            blo   <= reg_rdata;
            state <= S_BHI;
          end
        S_BHI:
          if (reg_ack) begin
            if (bcnt != 16'd0) begin
              left  <= bcnt;
              state <= S_CHUNK;
            end else if (tmo >= BURST_LIM) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
              err_q  <= 1'b1;
              code_q <= 8'h00;
            end else begin
              state <= S_BLO;
            end
          end
        S_CHUNK:
          if (reg_ack) begin
            idx  <= nxt_ix;
            left <= left - 16'd1;
            if (nxt_ix == last_ix || left == 16'd1) begin
              tmo   <= '0;
              kind  <= K_EXP;
              state <= S_WAIT;
            end
          end
        S_LAST:
          if (reg_ack) begin
            tmo   <= '0;
            kind  <= K_VAL;
            state <= S_WAIT;
          end
        S_GO:
          if (reg_ack) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_tx_seq_chk.sv
module cmd_tx_seq_chk #(
  parameter logic [7:0] STS_ADDR = 8'h18
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       reg_req,
  input logic       reg_ack,
  input logic       reg_we,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !reg_req);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

  assert_burst_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && (reg_addr == STS_ADDR + 8'd1 || reg_addr == STS_ADDR + 8'd2)) |-> !reg_we);

  assert_sts_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == STS_ADDR) |-> (reg_wdata == 8'h40 || reg_wdata == 8'h20));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

bind cmd_tx_seq cmd_tx_seq_chk #(.STS_ADDR(STS_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .reg_req(reg_req), .reg_ack(reg_ack), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/cmd_tx_seq_tb.sv
`timescale 1ns/1ps
module cmd_tx_seq_tb_top;
  localparam int LEN_W = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [LEN_W-1:0] buf_addr;
  logic [7:0]       buf_data;
  logic             reg_req, reg_we, reg_ack;
  logic [7:0]       reg_addr, reg_wdata, reg_rdata;
  logic             busy, done, err;
  logic [7:0]       err_code;

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7) + 3);
  endfunction

  assign buf_data = pat(int'(buf_addr));

  cmd_tx_seq #(.LEN_W(LEN_W), .BURST_TMO(64'd200), .WAIT_TMO(64'd400)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len),
    .buf_addr(buf_addr), .buf_data(buf_data),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
    .busy(busy), .done(done), .err(err), .err_code(err_code)
  );

  int n_chk = 0, n_err = 0;
  int exp_len, rdy_wait, zero_left;
  bit rdy, never_rdy, zero_all, stuck;
  logic [15:0] burst;
  int rx, run, max_run, n_fetch, n_abort, n_go, n_txn, viol;
  logic [7:0] rx_mem [0:511];
  bit p_pend;
  logic [7:0] p_addr, p_wdata;
  bit p_we;
  bit got_err;
  int got_code;

  always @(posedge clk) begin
    if (!rst_n) begin
      reg_ack <= 1'b0;
      reg_rdata <= 8'h00;
      p_pend = 1'b0;
    end else begin
      if (p_pend && (!reg_req || reg_addr != p_addr || reg_we != p_we || reg_wdata != p_wdata))
        viol++;
      p_pend = reg_req && !reg_ack;
      p_addr = reg_addr; p_we = reg_we; p_wdata = reg_wdata;
      reg_ack <= reg_req && !reg_ack;
      if (reg_req && !reg_ack) begin
        n_txn++;
        if (reg_we) begin
          if (reg_addr == 8'h24) begin
            if (rx < exp_len - 1) begin
              run++;
              if (run > max_run) max_run = run;
            end
            if (rx < 512) rx_mem[rx] = reg_wdata;
            rx++;
          end else if (reg_addr == 8'h18) begin
            if (reg_wdata == 8'h40) n_abort++;
            if (reg_wdata == 8'h20) n_go++;
          end
        end else begin
          case (reg_addr)
            8'h18: begin
              if (!rdy && n_abort > 0 && !never_rdy) begin
                if (rdy_wait == 0) rdy = 1'b1; else rdy_wait--;
              end
              reg_rdata <= {1'b1, rdy, 2'b00, (rx < exp_len) || stuck, 3'b000};
            end
            8'h19: reg_rdata <= (zero_all || zero_left > 0) ? 8'h00 : burst[7:0];
            8'h1A: begin
              if (zero_all || zero_left > 0) begin
                if (zero_left > 0) zero_left--;
                reg_rdata <= 8'h00;
              end else begin
                reg_rdata <= burst[15:8];
                n_fetch++;
                run = 0;
              end
            end
            default: reg_rdata <= 8'hFF;
          endcase
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got %0d cycles expected < 150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", r, act, expv);
    end
  endtask

  task automatic cfg(input int len, input bit r0, input int rw, input bit nr,
                     input logic [15:0] b, input int zl, input bit za, input bit st);
    exp_len = len; rdy = r0; rdy_wait = rw; never_rdy = nr;
    burst = b; zero_left = zl; zero_all = za; stuck = st;
    rx = 0; run = 0; max_run = 0; n_fetch = 0; n_abort = 0; n_go = 0; n_txn = 0;
  endtask

  task automatic launch(input int len);
    int w;
    @(negedge clk);
    cmd_len = LEN_W'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
    end
    chk(done, "run completes", w, 0);
    got_err = err;
    got_code = int'(err_code);
  endtask

  function automatic bit data_ok(input int len);
    for (int i = 0; i < len; i++)
      if (rx_mem[i] != pat(i)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic t_basic;
    cfg(10, 1, 0, 0, 16'd3, 0, 0, 0);
    launch(10);
    chk(n_abort == 0, "R2 no abort when ready", n_abort, 0);
    chk(n_fetch == 3, "R6 fetch per chunk", n_fetch, 3);
    chk(max_run <= 3, "R6 chunk bound", max_run, 3);
    chk(rx == 10 && data_ok(10), "R6 bytes in order", rx, 10);
    chk(!got_err && n_go == 1, "R8 go once, no err", n_go, 1);
  endtask

  task automatic t_abort;
    cfg(8, 0, 5, 0, 16'd4, 3, 0, 0);
    launch(8);
    chk(n_abort == 1, "R3 abort written", n_abort, 1);
    chk(n_fetch == 2, "R4 zero count retried", n_fetch, 2);
    chk(rx == 8 && data_ok(8), "R3 data after abort", rx, 8);
    chk(!got_err && n_go == 1, "R8 success after abort", int'(got_err), 0);
  endtask

  task automatic t_big;
    cfg(300, 1, 0, 0, 16'h0100, 0, 0, 0);
    launch(300);
    chk(n_fetch == 2, "R4 two-byte count", n_fetch, 2);
    chk(max_run == 256, "R4 count 256 assembled", max_run, 256);
    chk(rx == 300 && data_ok(300), "R6 long command", rx, 300);
  endtask

  task automatic t_len1;
    cfg(1, 1, 0, 0, 16'd3, 0, 0, 0);
    launch(1);
    chk(n_fetch == 0, "R10 no fetch for length 1", n_fetch, 0);
    chk(rx == 1 && rx_mem[0] == pat(0), "R10 single byte", rx, 1);
    chk(!got_err && n_go == 1, "R10 go issued", n_go, 1);
  endtask

  task automatic t_stuck;
    cfg(6, 1, 0, 0, 16'd2, 0, 0, 1);
    launch(6);
    chk(got_err, "R7 err on stuck expect", int'(got_err), 1);
    chk(got_code == 8'hC8, "R7 code is status", got_code, 8'hC8);
    chk(n_go == 0 && rx == 6, "R7 no go", n_go, 0);
  endtask

  task automatic t_burst_tmo;
    cfg(5, 1, 0, 0, 16'd2, 0, 1, 0);
    launch(5);
    chk(got_err && got_code == 0, "R5 burst timeout code", got_code, 0);
    chk(rx == 0 && n_go == 0, "R5 no data written", rx, 0);
  endtask

  task automatic t_wait_tmo;
    cfg(4, 0, 0, 1, 16'd2, 0, 0, 0);
    launch(4);
    chk(got_err && got_code == 8'h88, "R9 wait timeout code", got_code, 8'h88);
    chk(n_abort == 1 && rx == 0, "R9 no data after timeout", rx, 0);
  endtask

  task automatic t_len0;
    cfg(0, 1, 0, 0, 16'd2, 0, 0, 0);
    @(negedge clk);
    cmd_len = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(!busy && !done, "R11 zero length ignored", int'(busy), 0);
    chk(n_txn == 0, "R11 no bus access", n_txn, 0);
  endtask

  initial begin
    cfg(0, 1, 0, 0, 16'd1, 0, 0, 0);
    viol = 0;
    repeat (4) @(negedge clk);
    chk(!busy && !reg_req && !done && !err, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !reg_req, "R1 idle after reset", int'(reg_req), 0);
    t_basic();
    t_abort();
    t_big();
    t_len1();
    t_stuck();
    t_burst_tmo();
    t_wait_tmo();
    t_len0();
    chk(viol == 0, "R12 request held until ack", viol, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule